// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Request Controller

This block collects six interrupt request lines from the peripherals around it: two external inputs, three timers and one serial port. It masks them through an 8-bit enable register that holds one enable bit per source and a global gate. It ranks them through a one-bit-per-source priority register and presents one request together with a 3-bit vector index to the processor. The timer-2 line and the serial line are each formed by ORing two peripheral flags. The flags belong to the peripherals. The controller never clears them.

The processor answers a request with `ack_i`. The controller then records that the request's priority level is in service. A later `ret_i` closes the most recent service level. A high-level request may interrupt a low-level service. Nothing interrupts a high-level service. All outputs are combinational from the flag inputs and the registered state. A register write or an acknowledge takes effect from the next clock edge.

Top module: `irq_req_ctrl`

## Requirements
- R1: Enable register bits 0 to 5 enable, in order, external 0, timer 0, external 1, timer 1, serial, timer 2. Bit 7 is the global enable. A write to `en_wdata_i` with `en_wr_i` high shows on `en_rdata_o` after the next clock edge.
- R2: While enable bit 7 is 0, `irq_o` stays low whatever the flags and the other enable bits are.
- R3: Enable bit 6 is not stored. It always reads back as 0.
- R4: A source whose enable bit is 0 raises no request.
- R5: The timer-2 request is `tmr2_ovf_i` OR `tmr2_ext_i`. The serial request is `ser_tx_i` OR `ser_rx_i`.
- R6: Within one priority level, the source with the lowest index wins. `vec_o` carries that index: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2.
- R7: Priority register bit i set to 1 puts source i at the high level. A high-level request wins over any low-level request.
- R8: `ack_i` with `irq_o` high marks the level of the granted source as in service. `in_svc_o[0]` is low and `in_svc_o[1]` is high. While only low is in service, only high-level requests raise `irq_o`.
- R9: While the high level is in service, `irq_o` stays low.
- R10: `ret_i` clears the high in-service bit if it is set, and otherwise clears the low one.
- R11: Acknowledge leaves the flags alone. A request whose flag is still set is raised again once its level leaves service.
- R12: After reset, both registers read 0, `in_svc_o` is 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext0_flag_i | input | 1 | External 0 request flag |
| tmr0_flag_i | input | 1 | Timer 0 overflow flag |
| ext1_flag_i | input | 1 | External 1 request flag |
| tmr1_flag_i | input | 1 | Timer 1 overflow flag |
| ser_tx_i | input | 1 | Serial transmit-done flag |
| ser_rx_i | input | 1 | Serial receive-done flag |
| tmr2_ovf_i | input | 1 | Timer 2 overflow flag |
| tmr2_ext_i | input | 1 | Timer 2 external event flag |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| en_rdata_o | output | 8 | Enable register contents |
| pri_wr_i | input | 1 | Priority register write strobe |
| pri_wdata_i | input | 6 | Priority register write data |
| pri_rdata_o | output | 6 | Priority register contents |
| ack_i | input | 1 | Processor accepts the presented request |
| ret_i | input | 1 | Processor ends the current service level |
| irq_o | output | 1 | Request to the processor |
| vec_o | output | 3 | Index of the granted source |
| in_svc_o | output | 2 | In-service levels: bit 0 low, bit 1 high |

## Verification
The assertions place no limit on the flags. They assume only that `ack_i` has an effect when `irq_o` is high, and the design qualifies it that way itself. They also assume that `ret_i` with nothing in service changes nothing. The random stimulus therefore raises acknowledge and return on any cycle, including idle ones and cycles where both are high together. It mixes these with register rewrites, so that preemption, blocking and re-raising of requests whose flags stay set all occur within one run.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int NSRC = 6;
  localparam int VW   = $clog2(NSRC);
  localparam int REGW = NSRC + 2;
  localparam int GBIT = REGW - 1;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_wr_i,
  input  logic [REGW-1:0] en_wdata_i,
  input  logic            pri_wr_i,
  input  src_vec_t        pri_wdata_i,
  output src_vec_t        src_en_o,
  output logic            glb_en_o,
  output src_vec_t        pri_o,
  output logic [REGW-1:0] en_rd_o
);
  src_vec_t en_q, pri_q;
  logic     glb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      glb_q <= 1'b0;
      pri_q <= '0;
    end else begin
      if (en_wr_i) begin
        en_q  <= en_wdata_i[NSRC-1:0];
        glb_q <= en_wdata_i[GBIT];
      end
      if (pri_wr_i) pri_q <= pri_wdata_i;
    end
  end

  assign src_en_o = en_q;
  assign glb_en_o = glb_q;
  assign pri_o    = pri_q;
  // reserved bit between sources and global gate is not stored
  assign en_rd_o  = {glb_q, 1'b0, en_q};

  // R1
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i |=> (en_rd_o[GBIT] == $past(en_wdata_i[GBIT])) &&
                (en_rd_o[NSRC-1:0] == $past(en_wdata_i[NSRC-1:0])));
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  src_vec_t      pend_i,
  input  src_vec_t      pri_i,
  input  logic [1:0]    svc_i,
  output logic          irq_o,
  output logic [VW-1:0] vec_o,
  output logic          lvl_o
);
  src_vec_t hi_pend, lo_pend;
  logic [VW-1:0] hi_idx, lo_idx;
  logic hi_ok, lo_ok;

  assign hi_pend = pend_i & pri_i;
  assign lo_pend = pend_i & ~pri_i;

  // lowest index wins; scan from the top so the last hit is the lowest
  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (hi_pend[i]) hi_idx = VW'(i);
      if (lo_pend[i]) lo_idx = VW'(i);
    end
  end

  assign hi_ok = (|hi_pend) && !svc_i[1];
  assign lo_ok = (|lo_pend) && (svc_i == 2'b00);

  assign irq_o = hi_ok || lo_ok;
  assign lvl_o = hi_ok;
  assign vec_o = hi_ok ? hi_idx : (lo_ok ? lo_idx : '0);

  // R6
  grant_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_i[vec_o]);
  // R7
  level_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && (|hi_pend) && !svc_i[1]) |-> pri_i[vec_o]);
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ack_i,
  input  logic       ret_i,
  input  logic       irq_i,
  input  logic       lvl_i,
  output logic [1:0] svc_o
);
  logic [1:0] svc_q, clr, set;

  always_comb begin
    clr = 2'b00;
    set = 2'b00;
    if (ret_i) clr = svc_q[1] ? 2'b10 : 2'b01;
    if (ack_i && irq_i) set = lvl_i ? 2'b10 : 2'b01;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) svc_q <= 2'b00;
    else         svc_q <= (svc_q & ~clr) | set;
  end

  assign svc_o = svc_q;

  // R8
  ack_marks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_i) |=> svc_q[$past(lvl_i)]);
  // R10
  ret_pops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !ack_i && svc_q[1]) |=> (!svc_q[1] && svc_q[0] == $past(svc_q[0])));
endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl
  import irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext0_flag_i,
  input  logic       tmr0_flag_i,
  input  logic       ext1_flag_i,
  input  logic       tmr1_flag_i,
  input  logic       ser_tx_i,
  input  logic       ser_rx_i,
  input  logic       tmr2_ovf_i,
  input  logic       tmr2_ext_i,
  input  logic       en_wr_i,
  input  logic [7:0] en_wdata_i,
  output logic [7:0] en_rdata_o,
  input  logic       pri_wr_i,
  input  logic [5:0] pri_wdata_i,
  output logic [5:0] pri_rdata_o,
  input  logic       ack_i,
  input  logic       ret_i,
  output logic       irq_o,
  output logic [2:0] vec_o,
  output logic [1:0] in_svc_o
);
  src_vec_t req, src_en, pri, pend;
  logic     glb_en, lvl;

  // index order is the in-level priority order
  assign req = {tmr2_ovf_i | tmr2_ext_i, ser_tx_i | ser_rx_i,
                tmr1_flag_i, ext1_flag_i, tmr0_flag_i, ext0_flag_i};

  irq_cfg_regs u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_wr_i     (en_wr_i),
    .en_wdata_i  (en_wdata_i),
    .pri_wr_i    (pri_wr_i),
    .pri_wdata_i (pri_wdata_i),
    .src_en_o    (src_en),
    .glb_en_o    (glb_en),
    .pri_o       (pri),
    .en_rd_o     (en_rdata_o)
  );

  assign pend = req & src_en & {NSRC{glb_en}};

  irq_select u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .pri_i  (pri),
    .svc_i  (in_svc_o),
    .irq_o  (irq_o),
    .vec_o  (vec_o),
    .lvl_o  (lvl)
  );

  irq_svc_track u_svc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ack_i),
    .ret_i  (ret_i),
    .irq_i  (irq_o),
    .lvl_i  (lvl),
    .svc_o  (in_svc_o)
  );

  assign pri_rdata_o = pri;

  // R2
  glb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_rdata_o[7] |-> !irq_o);
  // R9
  hi_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_svc_o[1] |-> !irq_o);
  // R3
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_wr_i) |-> !en_rdata_o[6]);
endmodule

// File: tb/irq_req_ctrl_bench.sv
module irq_req_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic e0, t0, e1, t1, stx, srx, t2o, t2e;
  logic en_wr, pri_wr, ack, ret;
  logic [7:0] en_wd, en_rd;
  logic [5:0] pri_wd, pri_rd;
  logic irq;
  logic [2:0] vec;
  logic [1:0] svc;

  int checks = 0, fails = 0;
  logic [7:0] m_en = '0;
  logic [5:0] m_pri = '0;
  logic [1:0] m_svc = '0;

  always #5 clk = ~clk;

  irq_req_ctrl u_irq_req_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .ext0_flag_i(e0), .tmr0_flag_i(t0), .ext1_flag_i(e1), .tmr1_flag_i(t1),
    .ser_tx_i(stx), .ser_rx_i(srx), .tmr2_ovf_i(t2o), .tmr2_ext_i(t2e),
    .en_wr_i(en_wr), .en_wdata_i(en_wd), .en_rdata_o(en_rd),
    .pri_wr_i(pri_wr), .pri_wdata_i(pri_wd), .pri_rdata_o(pri_rd),
    .ack_i(ack), .ret_i(ret), .irq_o(irq), .vec_o(vec), .in_svc_o(svc)
  );

  // expected {irq, level, vec}
  function automatic logic [4:0] model();
    logic [5:0] rq, pd, hi, lo;
    logic [2:0] v;
    rq = {t2o | t2e, stx | srx, t1, e1, t0, e0};
    pd = rq & m_en[5:0] & {6{m_en[7]}};
    hi = pd & m_pri;
    lo = pd & ~m_pri;
    v = 3'd0;
    if (hi != 0 && !m_svc[1]) begin
      for (int i = 5; i >= 0; i--) if (hi[i]) v = 3'(i);
      return {1'b1, 1'b1, v};
    end
    if (lo != 0 && m_svc == 2'b00) begin
      for (int i = 5; i >= 0; i--) if (lo[i]) v = 3'(i);
      return {1'b1, 1'b0, v};
    end
    return 5'b0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic set_flags(logic [7:0] f);
    {t2e, t2o, srx, stx, t1, e1, t0, e0} = f;
  endtask

  // inputs already applied at negedge; check, then advance one edge
  task automatic step(string tag);
    logic [4:0] m;
    logic [1:0] clr, st;
    #1;
    m = model();
    chk(tag, "irq", int'(irq), int'(m[4]));
    if (m[4]) chk(tag, "vec", int'(vec), int'(m[2:0]));
    chk(tag, "in_svc", int'(svc), int'(m_svc));
    chk(tag, "en_rd", int'(en_rd), int'(m_en));
    chk(tag, "pri_rd", int'(pri_rd), int'(m_pri));
    @(posedge clk);
    clr = ret ? (m_svc[1] ? 2'b10 : 2'b01) : 2'b00;
    st  = (ack && m[4]) ? (m[3] ? 2'b10 : 2'b01) : 2'b00;
    m_svc = (m_svc & ~clr) | st;
    if (en_wr) m_en = en_wd & 8'hBF;
    if (pri_wr) m_pri = pri_wd;
    @(negedge clk);
    en_wr = 0; pri_wr = 0; ack = 0; ret = 0;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    set_flags(8'h00);
    en_wr = 0; pri_wr = 0; ack = 0; ret = 0; en_wd = 0; pri_wd = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    set_flags(8'hFF);
    step("R12");
    en_wr = 1; en_wd = 8'hFF; step("R1");
    step("R3");
    set_flags(8'h80); step("R5");       // tmr2 ext only -> vec 5
    set_flags(8'h40); step("R5");       // tmr2 ovf only
    set_flags(8'h20); step("R5");       // serial rx only -> vec 4
    set_flags(8'hFF); step("R6");       // all -> vec 0
    set_flags(8'h0C); step("R6");       // ext1+tmr1 -> vec 2
    pri_wr = 1; pri_wd = 6'b100000; step("R7");
    set_flags(8'hFF); ack = 1; step("R7");  // grant vec 5 high
    step("R9");
    ret = 1; step("R10");
    step("R11");                        // flags still set -> raised again
    pri_wr = 1; pri_wd = 6'b000000; step("R8");
    set_flags(8'h04); ack = 1; step("R8");  // low service, ext1
    set_flags(8'h05); step("R8");       // low-only requests blocked
    pri_wr = 1; pri_wd = 6'b000001; step("R8");
    step("R8");                         // high ext0 preempts
    ack = 1; step("R8");
    ret = 1; step("R10");
    ret = 1; step("R10");
    step("R11");
    en_wr = 1; en_wd = 8'h3F; step("R2");
    set_flags(8'hFF); step("R2");
    en_wr = 1; en_wd = 8'hF7; set_flags(8'h08); step("R4");
    step("R4");                         // tmr1 disabled -> no irq
    en_wr = 1; en_wd = 8'h40; step("R3");
    step("R3");
    for (int n = 0; n < 600; n++) begin
      set_flags(8'($urandom));
      en_wr  = ($urandom % 8) == 0;
      en_wd  = 8'($urandom) | 8'h80;
      if (($urandom % 6) == 0) en_wd[7] = 1'b0;
      pri_wr = ($urandom % 8) == 0;
      pri_wd = 6'($urandom);
      ack    = ($urandom % 3) == 0;
      ret    = ($urandom % 4) == 0;
      step("R6/R7/R8/R9/R10 rnd");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule